// File: doc/BRIEF.md
# Row-Locality Write Drain Arbiter

This block sits beside the request queues of a DRAM controller and makes the read/write choice for each scheduling step. It counts the pending writes, compares every queue entry against a per-bank table of activated rows, and from those two facts picks a drain mode and one request to issue. When the write queue fills to a high mark the controller turns to writes. An open-row hit can cut that write burst short, or carry it on after the low mark has been reached.

Selection inside the chosen queue favours the oldest entry that hits an open row. If no entry hits, the oldest valid entry is taken, and issuing it opens its row in the table. All results are combinational views of the current queue contents. The mode register, the open-row table and a one-cycle mode-change pulse advance only on a `step` strobe, which marks the cycle in which the controller issues the selected request.

Top module: `wdrain_arb`

## Requirements
- R1: After reset every bank is closed (no entry hits), the held mode is read (`drain_mode` = 0) and `mode_switch` is 0.
- R2: An entry hits when it is valid, its bank is open and its row equals that bank's open row. The same row in another bank does not hit.
- R3: Within the selected queue, index 0 is the oldest entry. The lowest-index hitting entry is selected with `sel_hit` = 1; with no hit, the lowest-index valid entry is selected with `sel_hit` = 0.
- R4: A `step` that issues a missing request opens that request's row in its bank from the next cycle on. A `step` that issues a hitting request leaves the table unchanged.
- R5: In read mode, when the write count is at or above `hi_mark`, the mode becomes write (`drain_mode` = 1) unless some read hits and no write hits.
- R6: In read mode at or above `hi_mark`, if some read hits and no write hits, the mode stays read.
- R7: In write mode, if some read hits and no write hits, the mode becomes read even while the write count is above `lo_mark`.
- R8: In write mode with the write count above `lo_mark`, and without the condition of R7, the mode stays write.
- R9: In write mode with the write count at or below `lo_mark`, if some write hits and no read hits, the mode stays write.
- R10: In write mode with the write count at or below `lo_mark`, and without the condition of R9, the mode returns to read.
- R11: If the queue picked by R5 to R10 is empty and the other is not, the other queue is selected and `drain_mode` names it. If both are empty, `sel_valid` is 0 and `drain_mode` shows the held mode.
- R12: The held mode changes only on `step`. `mode_switch` is 1 for exactly the cycle after a `step` in which `drain_mode` differed from the held mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | The selected request is issued this cycle |
| rd_valid | input | QDEPTH | Read entry valid bits, bit 0 oldest |
| rd_bank | input | QDEPTH*BANK_W | Read entry bank fields, entry i at bits i*BANK_W |
| rd_row | input | QDEPTH*ROW_W | Read entry row fields, entry i at bits i*ROW_W |
| wr_valid | input | QDEPTH | Write entry valid bits, bit 0 oldest |
| wr_bank | input | QDEPTH*BANK_W | Write entry bank fields |
| wr_row | input | QDEPTH*ROW_W | Write entry row fields |
| hi_mark | input | CNT_W | Write count that starts a drain |
| lo_mark | input | CNT_W | Write count at which a drain normally ends |
| drain_mode | output | 1 | 0 read queue, 1 write queue |
| sel_valid | output | 1 | A request is selected |
| sel_idx | output | IDX_W | Index of the selected entry |
| sel_hit | output | 1 | The selected entry hits its open row |
| mode_switch | output | 1 | One-cycle pulse after a mode change |

## Verification
Mode, selection and hit results depend combinationally on the queue inputs and the held state. The bench therefore drives the inputs on the falling edge and samples one time unit later, in the same cycle. Table updates, the held mode and `mode_switch` are due one rising edge after a `step`. The bench samples them at the falling edge that follows and then again one cycle later to see the pulse drop. Each watermark rule is set up from reset by priming banks with read steps, so the open rows and the held mode are known when the rule is checked.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } drain_mode_e;

    typedef struct packed {
        logic       any;
        logic       rd_only;
        logic       wr_only;
    } hit_summary_t;

    function automatic hit_summary_t summarize(logic rhit, logic whit);
        hit_summary_t s;
        s.any     = rhit | whit;
        s.rd_only = rhit & ~whit;
        s.wr_only = whit & ~rhit;
        return s;
    endfunction

    // Watermark and row-locality rules; counts are zero-extended to 16 bits.
    function automatic drain_mode_e decide_mode(
        drain_mode_e  cur,
        logic [15:0]  wcnt,
        logic [15:0]  hi,
        logic [15:0]  lo,
        hit_summary_t hs
    );
        drain_mode_e nxt;
        if (cur == MODE_RD) begin
            nxt = (wcnt >= hi && !hs.rd_only) ? MODE_WR : MODE_RD;
        end else if (hs.rd_only) begin
            nxt = MODE_RD;
        end else if (wcnt > lo) begin
            nxt = MODE_WR;
        end else if (hs.wr_only) begin
            nxt = MODE_WR;
        end else begin
            nxt = MODE_RD;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wdrain_open_rows.sv
module wdrain_open_rows #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       act_en,
    input  logic [BANK_W-1:0]          act_bank,
    input  logic [ROW_W-1:0]           act_row,
    output logic [NUM_BANKS-1:0]       open_vld,
    output logic [NUM_BANKS*ROW_W-1:0] open_row
);
    logic [ROW_W-1:0] row_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int b = 0; b < NUM_BANKS; b++) row_q[b] <= '0;
        end else if (act_en) begin
            vld_q[act_bank] <= 1'b1;
            row_q[act_bank] <= act_row;
        end
    end

    assign open_vld = vld_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
        assign open_row[b*ROW_W +: ROW_W] = row_q[b];
    end
endmodule

// File: rtl/wdrain_hit_vec.sv
module wdrain_hit_vec #(
    parameter int DEPTH     = 8,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [DEPTH-1:0]           valid,
    input  logic [DEPTH*BANK_W-1:0]    bank,
    input  logic [DEPTH*ROW_W-1:0]     row,
    input  logic [NUM_BANKS-1:0]       open_vld,
    input  logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic [DEPTH-1:0]           hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [BANK_W-1:0] b;
        assign b      = bank[i*BANK_W +: BANK_W];
        assign hit[i] = valid[i] && open_vld[b]
                        && (open_row[b*ROW_W +: ROW_W] == row[i*ROW_W +: ROW_W]);
    end
endmodule

// File: rtl/wdrain_pick.sv
module wdrain_pick #(
    parameter int DEPTH   = 8,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] hit,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic             idx_hit
);
    always_comb begin
        found   = 1'b0;
        idx     = '0;
        idx_hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (valid[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx     = IDX_W'(i);
                idx_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdrain_arb.sv
module wdrain_arb
    import wdrain_pkg::*;
#(
    parameter int QDEPTH    = 8,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(QDEPTH),
    localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic [QDEPTH-1:0]        rd_valid,
    input  logic [QDEPTH*BANK_W-1:0] rd_bank,
    input  logic [QDEPTH*ROW_W-1:0]  rd_row,
    input  logic [QDEPTH-1:0]        wr_valid,
    input  logic [QDEPTH*BANK_W-1:0] wr_bank,
    input  logic [QDEPTH*ROW_W-1:0]  wr_row,
    input  logic [CNT_W-1:0]         hi_mark,
    input  logic [CNT_W-1:0]         lo_mark,
    output logic                     drain_mode,
    output logic                     sel_valid,
    output logic [IDX_W-1:0]         sel_idx,
    output logic                     sel_hit,
    output logic                     mode_switch
);
    logic [NUM_BANKS-1:0]       open_vld;
    logic [NUM_BANKS*ROW_W-1:0] open_row;
    logic [QDEPTH-1:0]          rd_hit, wr_hit;
    logic                       rd_found, wr_found, rd_sel_hit, wr_sel_hit;
    logic [IDX_W-1:0]           rd_idx, wr_idx;
    logic                       rd_hit_any, wr_hit_any;
    logic [CNT_W-1:0]           wcnt;
    drain_mode_e                mode_q, want, eff;
    logic [BANK_W-1:0]          sel_bank;
    logic [ROW_W-1:0]           sel_row;
    logic                       act_en;

    wdrain_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst(rst), .act_en(act_en), .act_bank(sel_bank),
        .act_row(sel_row), .open_vld(open_vld), .open_row(open_row)
    );

    wdrain_hit_vec #(.DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_rd_hits (
        .valid(rd_valid), .bank(rd_bank), .row(rd_row),
        .open_vld(open_vld), .open_row(open_row), .hit(rd_hit)
    );

    wdrain_hit_vec #(.DEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_wr_hits (
        .valid(wr_valid), .bank(wr_bank), .row(wr_row),
        .open_vld(open_vld), .open_row(open_row), .hit(wr_hit)
    );

    wdrain_pick #(.DEPTH(QDEPTH)) u_rd_pick (
        .valid(rd_valid), .hit(rd_hit), .found(rd_found),
        .idx(rd_idx), .idx_hit(rd_sel_hit)
    );

    wdrain_pick #(.DEPTH(QDEPTH)) u_wr_pick (
        .valid(wr_valid), .hit(wr_hit), .found(wr_found),
        .idx(wr_idx), .idx_hit(wr_sel_hit)
    );

    assign rd_hit_any = |rd_hit;
    assign wr_hit_any = |wr_hit;
    assign wcnt       = CNT_W'($countones(wr_valid));

    always_comb begin
        want = decide_mode(mode_q, 16'(wcnt), 16'(hi_mark), 16'(lo_mark),
                           summarize(rd_hit_any, wr_hit_any));
        if (!rd_found && !wr_found)           eff = mode_q;
        else if (want == MODE_WR && !wr_found) eff = MODE_RD;
        else if (want == MODE_RD && !rd_found) eff = MODE_WR;
        else                                   eff = want;
    end

    always_comb begin
        if (eff == MODE_WR) begin
            sel_valid = wr_found;
            sel_idx   = wr_idx;
            sel_hit   = wr_sel_hit;
            sel_bank  = wr_bank[wr_idx*BANK_W +: BANK_W];
            sel_row   = wr_row[wr_idx*ROW_W +: ROW_W];
        end else begin
            sel_valid = rd_found;
            sel_idx   = rd_idx;
            sel_hit   = rd_sel_hit;
            sel_bank  = rd_bank[rd_idx*BANK_W +: BANK_W];
            sel_row   = rd_row[rd_idx*ROW_W +: ROW_W];
        end
    end

    assign act_en     = step && sel_valid && !sel_hit;
    assign drain_mode = eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_RD;
            mode_switch <= 1'b0;
        end else begin
            mode_switch <= step && (eff != mode_q);
            if (step) mode_q <= eff;
        end
    end
endmodule

// File: rtl/wdrain_arb_chk.sv
module wdrain_arb_chk #(
    parameter int QDEPTH    = 8,
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(QDEPTH),
    localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 step,
    input logic [QDEPTH-1:0]    rd_valid,
    input logic [QDEPTH-1:0]    wr_valid,
    input logic                 sel_valid,
    input logic [IDX_W-1:0]     sel_idx,
    input logic                 sel_hit,
    input logic                 drain_mode,
    input logic                 mode_switch,
    input logic                 mode_q,
    input logic                 rd_hit_any,
    input logic                 wr_hit_any,
    input logic [CNT_W-1:0]     wcnt,
    input logic [CNT_W-1:0]     hi_mark,
    input logic [BANK_W-1:0]    sel_bank,
    input logic [NUM_BANKS-1:0] open_vld
);
    assert_sel_entry_valid_R3: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (drain_mode ? wr_valid[sel_idx] : rd_valid[sel_idx]));

    assert_activate_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (step && sel_valid && !sel_hit) |=> open_vld[$past(sel_bank)]);

    assert_high_forces_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && wcnt >= hi_mark && !(rd_hit_any && !wr_hit_any) && wr_valid != '0)
        |-> drain_mode);

    assert_early_read_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q && rd_hit_any && !wr_hit_any) |-> !drain_mode);

    assert_both_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid == '0 && wr_valid == '0) |-> (!sel_valid && drain_mode == mode_q));

    assert_mode_held_R12: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(mode_q));

    assert_pulse_after_step_R12: assert property (@(posedge clk) disable iff (rst)
        mode_switch |-> $past(step));
endmodule

bind wdrain_arb wdrain_arb_chk #(.QDEPTH(QDEPTH), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst(rst), .step(step), .rd_valid(rd_valid), .wr_valid(wr_valid),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_hit(sel_hit),
    .drain_mode(drain_mode), .mode_switch(mode_switch), .mode_q(mode_q),
    .rd_hit_any(rd_hit_any), .wr_hit_any(wr_hit_any), .wcnt(wcnt),
    .hi_mark(hi_mark), .sel_bank(sel_bank), .open_vld(open_vld)
);

// File: tb/wdrain_arb_tb.sv
module wdrain_arb_tb_top;
    localparam int QD = 8;
    localparam int NB = 4;
    localparam int RW = 14;
    localparam int BW = $clog2(NB);
    localparam int IW = $clog2(QD);
    localparam int CW = $clog2(QD + 1);

    logic clk = 1'b0;
    logic rst, step;
    logic [QD-1:0] rv, wv;
    logic [BW-1:0] rb_a [QD];
    logic [BW-1:0] wb_a [QD];
    logic [RW-1:0] rr_a [QD];
    logic [RW-1:0] wr_a [QD];
    logic [QD*BW-1:0] rd_bank, wr_bank;
    logic [QD*RW-1:0] rd_row, wr_row;
    logic [CW-1:0] hi_mark, lo_mark;
    logic drain_mode, sel_valid, sel_hit, mode_switch;
    logic [IW-1:0] sel_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < QD; i++) begin
            rd_bank[i*BW +: BW] = rb_a[i];
            wr_bank[i*BW +: BW] = wb_a[i];
            rd_row[i*RW +: RW]  = rr_a[i];
            wr_row[i*RW +: RW]  = wr_a[i];
        end
    end

    wdrain_arb #(.QDEPTH(QD), .NUM_BANKS(NB), .ROW_W(RW)) dut_i (
        .clk(clk), .rst(rst), .step(step),
        .rd_valid(rv), .rd_bank(rd_bank), .rd_row(rd_row),
        .wr_valid(wv), .wr_bank(wr_bank), .wr_row(wr_row),
        .hi_mark(hi_mark), .lo_mark(lo_mark),
        .drain_mode(drain_mode), .sel_valid(sel_valid), .sel_idx(sel_idx),
        .sel_hit(sel_hit), .mode_switch(mode_switch)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        rv = '0; wv = '0;
        for (int i = 0; i < QD; i++) begin
            rb_a[i] = '0; wb_a[i] = '0; rr_a[i] = '0; wr_a[i] = '0;
        end
    endtask

    task automatic set_rd(int i, int b, int r);
        rv[i] = 1'b1; rb_a[i] = BW'(b); rr_a[i] = RW'(r);
    endtask

    task automatic set_wr(int i, int b, int r);
        wv[i] = 1'b1; wb_a[i] = BW'(b); wr_a[i] = RW'(r);
    endtask

    task automatic settle();
        #1;
    endtask

    // Issue on the next rising edge, return at the falling edge after it.
    task automatic do_step();
        step = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step = 1'b0;
        clear_q();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic prime(int b, int r);
        @(negedge clk);
        clear_q();
        set_rd(0, b, r);
        do_step();
        @(negedge clk);
        clear_q();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "drain_mode", drain_mode, 0);
        chk("R1", "sel_valid", sel_valid, 0);
        chk("R1", "mode_switch", mode_switch, 0);
        @(negedge clk);
        set_rd(0, 2, 7);
        settle();
        chk("R1", "sel_hit closed bank", sel_hit, 0);
    endtask

    task automatic t_hit_select();
        do_reset();
        @(negedge clk);
        set_rd(0, 1, 5);
        settle();
        chk("R2", "miss before activate", sel_hit, 0);
        do_step();
        chk("R4", "hit after activate", sel_hit, 1);
        chk("R12", "no pulse in read", mode_switch, 0);
        do_step();
        chk("R4", "hit step keeps row", sel_hit, 1);
        @(negedge clk);
        clear_q();
        set_rd(0, 2, 5);
        set_rd(1, 1, 6);
        set_rd(2, 1, 5);
        set_rd(3, 1, 5);
        settle();
        chk("R2", "other bank same row misses, idx", sel_idx, 2);
        chk("R3", "oldest hit selected", sel_hit, 1);
        @(negedge clk);
        clear_q();
        set_rd(2, 3, 1);
        set_rd(5, 3, 2);
        settle();
        chk("R3", "oldest valid idx", sel_idx, 2);
        chk("R3", "oldest valid miss", sel_hit, 0);
    endtask

    task automatic t_drain_start();
        do_reset();
        prime(1, 5);
        set_rd(0, 3, 9);
        for (int i = 0; i < 6; i++) set_wr(i, 2, i + 1);
        settle();
        chk("R5", "drain at high mark", drain_mode, 1);
        chk("R5", "write idx", sel_idx, 0);
        wv[5] = 1'b0;
        settle();
        chk("R5", "below high stays read", drain_mode, 0);
        wv[5] = 1'b1;
        settle();
        do_step();
        chk("R12", "pulse after change", mode_switch, 1);
        @(negedge clk);
        settle();
        chk("R12", "pulse one cycle", mode_switch, 0);
    endtask

    task automatic t_read_override();
        do_reset();
        prime(1, 5);
        set_rd(0, 1, 5);
        for (int i = 0; i < 6; i++) set_wr(i, 2, i + 1);
        settle();
        chk("R6", "read hit keeps read", drain_mode, 0);
        set_wr(3, 1, 5);
        settle();
        chk("R5", "both hit forces write", drain_mode, 1);
        chk("R3", "write hit idx", sel_idx, 3);
        do_step();
        do_step();
        chk("R12", "no pulse when unchanged", mode_switch, 0);
    endtask

    task automatic enter_write();
        do_reset();
        prime(1, 5);
        set_rd(0, 3, 9);
        for (int i = 0; i < 6; i++) set_wr(i, 2, i + 1);
        do_step();
        @(negedge clk);
        clear_q();
    endtask

    task automatic t_write_rules();
        enter_write();
        for (int i = 0; i < 5; i++) set_wr(i, 3, i + 1);
        set_rd(0, 3, 9);
        settle();
        chk("R8", "above low stays write", drain_mode, 1);
        set_rd(0, 1, 5);
        settle();
        chk("R7", "read hit leaves early", drain_mode, 0);
        chk("R7", "read hit selected", sel_hit, 1);
        set_wr(4, 2, 1);
        settle();
        chk("R8", "write hit keeps write", drain_mode, 1);
        chk("R8", "write hit idx", sel_idx, 4);
        @(negedge clk);
        clear_q();
        set_wr(0, 3, 1);
        set_wr(1, 2, 1);
        set_rd(0, 3, 9);
        settle();
        chk("R9", "write hit extends drain", drain_mode, 1);
        chk("R9", "extend idx", sel_idx, 1);
        set_rd(0, 1, 5);
        settle();
        chk("R10", "both hit at low ends drain", drain_mode, 0);
        set_rd(0, 3, 9);
        set_wr(1, 3, 2);
        settle();
        chk("R10", "no hit at low ends drain", drain_mode, 0);
        @(negedge clk);
        clear_q();
        settle();
        chk("R11", "both empty holds write", drain_mode, 1);
        chk("R11", "both empty none selected", sel_valid, 0);
    endtask

    task automatic t_fallback();
        do_reset();
        set_wr(0, 0, 3);
        settle();
        chk("R11", "empty reads fall back", drain_mode, 1);
        chk("R11", "fallback valid", sel_valid, 1);
        do_step();
        chk("R12", "fallback pulse", mode_switch, 1);
        @(negedge clk);
        clear_q();
        settle();
        chk("R11", "held write shown", drain_mode, 1);
    endtask

    initial begin
        rst = 1'b1; step = 1'b0;
        hi_mark = CW'(6); lo_mark = CW'(2);
        clear_q();
        t_reset();
        t_hit_select();
        t_drain_start();
        t_read_override();
        t_write_rules();
        t_fallback();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule